// File: doc/BRIEF.md
# Guarded Status Flag Register Bank

This block holds a small bank of byte-wide control and status registers that sit on an 8-bit register bus. Five bits in the bank are event flags: two timer overflow flags, two external interrupt flags and one watchdog overflow flag. Peripheral logic can set any of them with a one-cycle pulse at any time, including while the CPU is rewriting the same register.

The CPU rewrites a register either with a plain write or with a read-modify-write. A read-modify-write is marked by an `rmwRead` strobe, then later an `rmwWrite` strobe to the same address. Every guarded flag has a "set since read" latch. The latch is cleared when its register gets an `rmwRead` and is set by the flag's hardware pulse. On the `rmwWrite` write-back, any flag whose latch is set stays 1, even if the written byte has a 0 in that bit. This means a clear based on a stale read cannot lose an event. Plain writes ignore the latches.

The bus port accepts 16-bit data but uses only the low byte. Read data is combinational from the address, and its upper byte is always zero.

Top module: `guarded_sfr`

## Requirements
- R1: After reset, both registers read 0x00 and `flagsOut` is 0.
- R2: A plain write (`wrEn`) stores `wrData[7:0]` into the addressed register on the next clock edge, and `wrData[15:8]` is ignored. Address 0 has all eight bits writable. Address 1 implements only bits 2:0, so its bits 7:3 always read 0.
- R3: `rdData[15:8]` is always 0, and `rdData[7:0]` shows the register selected by `busAddr` in the same cycle.
- R4: A pulse on `hwSet[i]` sets flag i on the next edge. The flags map to register bits as follows: flag 0 is address 0 bit 1, flag 1 is address 0 bit 3, flag 2 is address 0 bit 5, flag 3 is address 0 bit 7, and flag 4 is address 1 bit 2. `flagsOut[i]` mirrors flag i.
- R5: Suppose a flag's `hwSet` pulse arrives after an `rmwRead` of its register and before the `rmwWrite`. That flag reads 1 after the `rmwWrite`, whatever value was written. The other bits take the written value.
- R6: If no set pulse arrived since the `rmwRead`, the `rmwWrite` stores the written byte as-is, which can clear flags.
- R7: A plain write updates guarded flags to the written value, even when their set-since-read latch is set.
- R8: If a hardware set and a software clear (plain or read-modify-write) of the same flag happen in the same cycle, the flag ends up set.
- R9: Addresses 2 and 3 are unmapped. Writes to them change nothing, and reads from them return 0.
- R10: A set pulse in the same cycle as the `rmwRead` counts as arriving after the read. The read returns the old value, and the flag survives the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address |
| wrEn | input | 1 | Plain write strobe |
| rmwRead | input | 1 | Read phase of a read-modify-write |
| rmwWrite | input | 1 | Write-back phase of a read-modify-write |
| wrData | input | 16 | Write data; only the low byte is used |
| hwSet | input | 5 | One-cycle set pulses from peripherals, one per flag |
| rdData | output | 16 | Read data; upper byte is zero |
| flagsOut | output | 5 | Current value of each guarded flag |

## Verification
A peripheral set pulse and a CPU write to the same register can land in the same cycle, and so can a set pulse and an `rmwRead`. The bench drives `hwSet` together with a clearing plain write and with a clearing `rmwWrite`, and expects the flag to read 1 afterwards. It also raises `hwSet` together with `rmwRead` and expects two things: the read returns the pre-set value, and the flag survives the later write-back. The protection window is also tested on its own, with the pulse placed strictly between the two strobes for both registers.

// File: rtl/guarded_sfr_pkg.sv
package guarded_sfr_pkg;
  localparam int REG_W     = 8;
  localparam int BUS_W     = 16;
  localparam int NUM_REGS  = 2;
  localparam int NUM_FLAGS = 5;

  // register holding each flag
  function automatic int flagReg(input int f);
    return (f == 4) ? 1 : 0;
  endfunction

  // bit position of each flag inside its register
  function automatic int flagBit(input int f);
    case (f)
      0:       return 1;
      1:       return 3;
      2:       return 5;
      3:       return 7;
      default: return 2;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] implMask(input int r);
    return (r == 1) ? REG_W'(8'h07) : {REG_W{1'b1}};
  endfunction

  function automatic logic [REG_W-1:0] guardMask(input int r);
    logic [REG_W-1:0] m;
    m = '0;
    for (int f = 0; f < NUM_FLAGS; f++)
      if (flagReg(f) == r) m[flagBit(f)] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_FLAGS-1:0] flagsOfReg(input int r);
    logic [NUM_FLAGS-1:0] m;
    m = '0;
    for (int f = 0; f < NUM_FLAGS; f++)
      if (flagReg(f) == r) m[f] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic [NUM_REGS-1:0] plainWr;
    logic [NUM_REGS-1:0] rmwWr;
    logic [NUM_REGS-1:0] rmwRd;
    logic [NUM_REGS-1:0] rdSel;
  } gsrStrobes_t;
endpackage

// File: rtl/guarded_sfr_ctrl.sv
module guarded_sfr_ctrl
  import guarded_sfr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rmwRead,
  input  logic              rmwWrite,
  output gsrStrobes_t       stb
);
  always_comb begin
    stb = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (int'(busAddr) == r) begin
        stb.rdSel[r]   = 1'b1;
        stb.rmwRd[r]   = rmwRead;
        stb.rmwWr[r]   = rmwWrite;
        stb.plainWr[r] = wrEn & ~rmwWrite;
      end
    end
  end
endmodule

// File: rtl/guarded_sfr_dp.sv
module guarded_sfr_dp
  import guarded_sfr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  gsrStrobes_t          stb,
  input  logic [REG_W-1:0]     wrByte,
  input  logic [NUM_FLAGS-1:0] hwSet,
  output logic [REG_W-1:0]     rdByte,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  logic [NUM_REGS-1:0][REG_W-1:0] regQ;
  logic [NUM_REGS-1:0][REG_W-1:0] latchQ;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [REG_W-1:0] IMPL  = implMask(r);
    localparam logic [REG_W-1:0] GUARD = guardMask(r);
    logic [REG_W-1:0] setVec;
    logic [REG_W-1:0] regD;
    logic [REG_W-1:0] latchD;

    always_comb begin
      setVec = '0;
      for (int f = 0; f < NUM_FLAGS; f++)
        if (flagReg(f) == r) setVec = setVec | (REG_W'(hwSet[f]) << flagBit(f));
    end

    always_comb begin
      regD = regQ[r];
      if (stb.rmwWr[r])        regD = (wrByte & IMPL) | (latchQ[r] & GUARD);
      else if (stb.plainWr[r]) regD = wrByte & IMPL;
      regD = regD | setVec;     // hardware set wins
      latchD = latchQ[r];
      if (stb.rmwRd[r]) latchD = '0;
      latchD = (latchD | setVec) & GUARD;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[r]   <= '0;
        latchQ[r] <= '0;
      end else begin
        regQ[r]   <= regD;
        latchQ[r] <= latchD;
      end
    end
  end

  always_comb begin
    rdByte = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (stb.rdSel[r]) rdByte = rdByte | regQ[r];
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    assign flagsOut[f] = regQ[flagReg(f)][flagBit(f)];
  end
endmodule

// File: rtl/guarded_sfr.sv
module guarded_sfr
  import guarded_sfr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 wrEn,
  input  logic                 rmwRead,
  input  logic                 rmwWrite,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [NUM_FLAGS-1:0] hwSet,
  output logic [BUS_W-1:0]     rdData,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  gsrStrobes_t      stb;
  logic [REG_W-1:0] rdByte;
  logic             unusedUpper;

  assign unusedUpper = ^wrData[BUS_W-1:REG_W];

  guarded_sfr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .wrEn    (wrEn),
    .rmwRead (rmwRead),
    .rmwWrite(rmwWrite),
    .stb     (stb)
  );

  guarded_sfr_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrByte  (wrData[REG_W-1:0]),
    .hwSet   (hwSet),
    .rdByte  (rdByte),
    .flagsOut(flagsOut)
  );

  assign rdData = {{(BUS_W-REG_W){1'b0}}, rdByte};
endmodule

// File: rtl/guarded_sfr_chk.sv
module guarded_sfr_chk
  import guarded_sfr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 wrEn,
  input logic                 rmwRead,
  input logic                 rmwWrite,
  input logic [NUM_FLAGS-1:0] hwSet,
  input logic [BUS_W-1:0]     rdData,
  input logic [NUM_FLAGS-1:0] flagsOut
);
  logic [NUM_FLAGS-1:0] seenQ;
  logic [NUM_FLAGS-1:0] addrFlags;
  logic [NUM_FLAGS-1:0] protect;

  always_comb begin
    addrFlags = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (int'(busAddr) == r) addrFlags = flagsOfReg(r);
  end
  assign protect = seenQ & addrFlags;

  always_ff @(posedge clk) begin
    if (!rstN) seenQ <= '0;
    else begin
      for (int f = 0; f < NUM_FLAGS; f++) begin
        if (rmwRead && addrFlags[f]) seenQ[f] <= hwSet[f];
        else if (hwSet[f])           seenQ[f] <= 1'b1;
      end
    end
  end

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BUS_W-1:REG_W] == '0);

  // R4
  hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwSet != '0) |=> ((flagsOut & $past(hwSet)) == $past(hwSet)));

  // R5
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rmwWrite && (protect != '0)) |=> ((flagsOut & $past(protect)) == $past(protect)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) >= NUM_REGS) |-> (rdData == '0));

  // R2
  unimpl_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) == 1) |-> (rdData[7:3] == 5'b0));

  // R4
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rmwWrite && hwSet == '0) |=> $stable(flagsOut));
endmodule

bind guarded_sfr guarded_sfr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .wrEn    (wrEn),
  .rmwRead (rmwRead),
  .rmwWrite(rmwWrite),
  .hwSet   (hwSet),
  .rdData  (rdData),
  .flagsOut(flagsOut)
);

// File: tb/guarded_sfr_tb.sv
module guarded_sfr_tb;
  localparam int ADDR_W = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  busAddr;
  logic        wrEn, rmwRead, rmwWrite;
  logic [15:0] wrData;
  logic [4:0]  hwSet;
  logic [15:0] rdData;
  logic [4:0]  flagsOut;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  guarded_sfr #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .rmwRead(rmwRead),
    .rmwWrite(rmwWrite), .wrData(wrData), .hwSet(hwSet), .rdData(rdData),
    .flagsOut(flagsOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; rmwRead = 0; rmwWrite = 0; hwSet = '0;
  endtask

  task automatic plainWrite(input logic [1:0] a, input logic [15:0] d, input logic [4:0] s);
    @(negedge clk); busAddr = a; wrData = d; wrEn = 1; hwSet = s;
    @(negedge clk); idle();
  endtask

  task automatic rmwWriteOp(input logic [1:0] a, input logic [15:0] d, input logic [4:0] s);
    @(negedge clk); busAddr = a; wrData = d; rmwWrite = 1; hwSet = s;
    @(negedge clk); idle();
  endtask

  task automatic rmwReadOp(input logic [1:0] a, input logic [4:0] s, output logic [15:0] v);
    @(negedge clk); busAddr = a; rmwRead = 1; hwSet = s;
    #1 v = rdData;
    @(negedge clk); idle();
  endtask

  task automatic pulseSet(input logic [4:0] s);
    @(negedge clk); hwSet = s;
    @(negedge clk); idle();
  endtask

  task automatic readAt(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); busAddr = a;
    #1 v = rdData;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    readAt(2'd0, v); check("R1 reg0", v, 16'h0000);
    readAt(2'd1, v); check("R1 reg1", v, 16'h0000);
    check("R1 flags", 16'(flagsOut), 16'h0000);
  endtask

  task automatic t_plain();
    logic [15:0] v;
    plainWrite(2'd0, 16'hA55A, 5'b0);
    readAt(2'd0, v); check("R2/R3 reg0 low byte", v, 16'h005A);
    plainWrite(2'd1, 16'hFFFF, 5'b0);
    readAt(2'd1, v); check("R2 reg1 unimpl bits", v, 16'h0007);
    check("R4 flags mirror", 16'(flagsOut), 16'h0013);
    plainWrite(2'd0, 16'h0000, 5'b0);
    plainWrite(2'd1, 16'h0000, 5'b0);
  endtask

  task automatic t_hwset();
    logic [15:0] v;
    pulseSet(5'b00100);
    readAt(2'd0, v); check("R4 tf0 set", v, 16'h0020);
    check("R4 flagsOut", 16'(flagsOut), 16'h0004);
  endtask

  task automatic t_guard();
    logic [15:0] v;
    plainWrite(2'd0, 16'h0000, 5'b0);
    rmwReadOp(2'd0, 5'b0, v);
    pulseSet(5'b01000);
    rmwWriteOp(2'd0, 16'h0001, 5'b0);
    readAt(2'd0, v); check("R5 reg0 guarded", v, 16'h0081);
    plainWrite(2'd1, 16'h0000, 5'b0);
    rmwReadOp(2'd1, 5'b0, v);
    pulseSet(5'b10000);
    rmwWriteOp(2'd1, 16'h0001, 5'b0);
    readAt(2'd1, v); check("R5 reg1 guarded", v, 16'h0005);
  endtask

  task automatic t_noguard();
    logic [15:0] v;
    rmwReadOp(2'd0, 5'b0, v); check("R6 rmw read value", v, 16'h0081);
    rmwWriteOp(2'd0, 16'h0000, 5'b0);
    readAt(2'd0, v); check("R6 cleared", v, 16'h0000);
  endtask

  task automatic t_readSameCycle();
    logic [15:0] v;
    plainWrite(2'd0, 16'h0000, 5'b0);
    rmwReadOp(2'd0, 5'b00001, v); check("R10 old value read", v, 16'h0000);
    rmwWriteOp(2'd0, 16'h0000, 5'b0);
    readAt(2'd0, v); check("R10 flag kept", v, 16'h0002);
  endtask

  task automatic t_plainClear();
    logic [15:0] v;
    plainWrite(2'd0, 16'h0000, 5'b0);
    rmwReadOp(2'd0, 5'b0, v);
    pulseSet(5'b00010);
    readAt(2'd0, v); check("R7 set seen", v, 16'h0008);
    plainWrite(2'd0, 16'h0000, 5'b0);
    readAt(2'd0, v); check("R7 plain clears", v, 16'h0000);
  endtask

  task automatic t_setWins();
    logic [15:0] v;
    plainWrite(2'd0, 16'h00FF, 5'b0);
    plainWrite(2'd0, 16'h0000, 5'b00100);
    readAt(2'd0, v); check("R8 plain vs set", v, 16'h0020);
    plainWrite(2'd1, 16'h0000, 5'b0);
    rmwReadOp(2'd1, 5'b0, v);
    rmwWriteOp(2'd1, 16'h0000, 5'b10000);
    readAt(2'd1, v); check("R8 rmw vs set", v, 16'h0004);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    plainWrite(2'd2, 16'hFFFF, 5'b0);
    plainWrite(2'd3, 16'hFFFF, 5'b0);
    readAt(2'd2, v); check("R9 addr2 reads 0", v, 16'h0000);
    readAt(2'd3, v); check("R9 addr3 reads 0", v, 16'h0000);
    readAt(2'd0, v); check("R9 reg0 untouched", v, 16'h0020);
    readAt(2'd1, v); check("R9 reg1 untouched", v, 16'h0004);
  endtask

  initial begin
    rstN = 0; busAddr = '0; wrData = '0; idle();
    repeat (4) @(negedge clk);
    rstN = 1;
    t_reset();
    t_plain();
    t_hwset();
    t_guard();
    t_noguard();
    t_readSameCycle();
    t_plainClear();
    t_setWins();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule